// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block keeps the machine-level trap state of a small in-order pipeline: the current privilege mode, the global interrupt enable, the saved copy of that enable, the saved previous mode, the exception return address and the trap vector base. When the pipeline raises a synchronous exception, the block accepts it unconditionally. When an external interrupt is pending, the block accepts it only while interrupts are enabled. On acceptance it saves the state and asks fetch to restart at the vector. The pipeline supplies the address of the oldest instruction that has not committed, which is the instruction that will be re-executed after the handler.

A return-from-machine-trap request pops that saved state. The mode and the interrupt enable are restored from their saved copies, the saved enable is set to 1 and the saved mode falls back to user. Fetch is redirected to the stored return address. A small register port lets software read and write the status word, the return address and the vector. Redirect requests are combinational, so the pipeline sees them in the same cycle as the request that caused them.

Top module: `mtrap_csr`

## Requirements
- R1: After reset the mode is machine (2'b11), the interrupt enable and saved enable are 0, the saved mode is 2'b00, and the return address and vector both read 0.
- R2: An exception request is always accepted. An interrupt request is accepted only while the interrupt enable is 1. In the cycle of acceptance, redirect_valid is 1 and redirect_pc equals the vector. A masked interrupt produces no redirect and changes no state.
- R3: On an accepted trap, the following updates take effect at the next edge. The return address takes trap_pc with its two low bits cleared. The saved mode takes the current mode and the saved enable takes the current enable. The enable clears to 0 and the mode becomes machine.
- R4: A return request that is not pre-empted by a trap raises redirect_valid in the same cycle, with redirect_pc equal to the return address. At the next edge the mode takes the saved mode and the enable takes the saved enable. The saved enable becomes 1 and the saved mode becomes user (2'b00).
- R5: When a trap is accepted in the same cycle as a return request, the trap wins: the redirect goes to the vector, the trap entry of R3 takes place, and the return has no effect.
- R6: The register port selects by csr_sel. 2'b00 is the status word, with the enable at bit 3, the saved enable at bit 7, the saved mode at bits 12:11 and zeros elsewhere. 2'b01 is the return address and 2'b10 is the vector. 2'b11 reads 0 and ignores writes. Reads are combinational.
- R7: Bits 1:0 of the return address and of the vector always read 0, whatever value is written.
- R8: A status write whose saved-mode field is 2'b11 stores 2'b11. Any other value in that field stores 2'b00.
- R9: A register write in the same cycle as an accepted trap or an effective return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| irq_req | input | 1 | Pending external interrupt |
| trap_pc | input | XLEN | Address of oldest uncommitted instruction |
| mret | input | 1 | Return-from-trap request |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | XLEN | Fetch redirect target |
| cur_mode | output | 2 | Current privilege mode |
| irq_en | output | 1 | Global interrupt enable |

## Verification
The bench targets a trap taken from user mode followed by a return. A design that saved the mode after forcing it to machine would resume the program in machine mode. It also checks that the saved enable reads 1 and the saved mode reads 0 after a return; a design that skipped that reset would re-enter the wrong mode on a second return. An interrupt arriving while masked must leave every register untouched. A trap colliding with a return, or with a register write, must give the trap sole effect; a wrong priority would send fetch to the stale return address or corrupt the vector.

// File: rtl/mtrap_csr.sv
module mtrap_csr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            irq_req,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            mret,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      cur_mode,
  output logic            irq_en
);
  localparam logic [1:0] MODE_M = 2'b11;
  localparam logic [1:0] MODE_U = 2'b00;
  localparam int EN_BIT = 3;
  localparam int PEN_BIT = 7;
  localparam int PM_LO = 11;

  logic [1:0]      mode_q, mpp_q;
  logic            mie_q, mpie_q;
  logic [XLEN-1:0] epc_q, vec_q;
  logic [XLEN-1:0] status_w;
  logic            take, ret;

  assign take = exc_req | (irq_req & mie_q);
  assign ret  = mret & ~take;

  assign redirect_valid = take | ret;
  assign redirect_pc    = take ? vec_q : epc_q;
  assign cur_mode       = mode_q;
  assign irq_en         = mie_q;

  always_comb begin
    status_w = '0;
    status_w[EN_BIT] = mie_q;
    status_w[PEN_BIT] = mpie_q;
    status_w[PM_LO+1:PM_LO] = mpp_q;
  end

  always_comb begin
    case (csr_sel)
      2'b00:   csr_rdata = status_w;
      2'b01:   csr_rdata = epc_q;
      2'b10:   csr_rdata = vec_q;
      default: csr_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{trap_pc[1:0], csr_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_M;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      mpp_q  <= MODE_U;
      epc_q  <= '0;
      vec_q  <= '0;
    end else if (take) begin
      epc_q  <= {trap_pc[XLEN-1:2], 2'b00};
      mpp_q  <= mode_q;
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      mode_q <= MODE_M;
    end else if (ret) begin
      mode_q <= mpp_q;
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      mpp_q  <= MODE_U;
    end else if (csr_we) begin
      case (csr_sel)
        2'b00: begin
          mie_q  <= csr_wdata[EN_BIT];
          mpie_q <= csr_wdata[PEN_BIT];
          mpp_q  <= (csr_wdata[PM_LO+1:PM_LO] == MODE_M) ? MODE_M : MODE_U;
        end
        2'b01:   epc_q <= {csr_wdata[XLEN-1:2], 2'b00};
        2'b10:   vec_q <= {csr_wdata[XLEN-1:2], 2'b00};
        default: ;
      endcase
    end
  end
endmodule

module mtrap_csr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            irq_req,
  input logic            mret,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [1:0]      mode_q,
  input logic [1:0]      mpp_q,
  input logic            mie_q,
  input logic            mpie_q,
  input logic [XLEN-1:0] vec_q
);
  assert_trap_enters_machine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req || (irq_req && mie_q)) |=> (mode_q == 2'b11 && !mie_q));

  assert_masked_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !mie_q && !exc_req && !mret) |-> !redirect_valid);

  assert_mret_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !exc_req && !(irq_req && mie_q)) |=>
      (mie_q == $past(mpie_q) && mode_q == $past(mpp_q) && mpie_q && mpp_q == 2'b00));

  assert_trap_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && exc_req) |-> (redirect_valid && redirect_pc == vec_q));

  assert_redirect_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[1:0] == 2'b00));
endmodule

bind mtrap_csr mtrap_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .irq_req(irq_req), .mret(mret),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .mode_q(mode_q),
  .mpp_q(mpp_q), .mie_q(mie_q), .mpie_q(mpie_q), .vec_q(vec_q)
);

// File: tb/tb_mtrap_csr.sv
module tb_mtrap_csr;
  localparam int XLEN = 32;
  logic clk = 0, rst_n = 0;
  logic exc_req = 0, irq_req = 0, mret = 0, csr_we = 0;
  logic [1:0] csr_sel = 0;
  logic [XLEN-1:0] trap_pc = 0, csr_wdata = 0, csr_rdata, redirect_pc;
  logic redirect_valid, irq_en;
  logic [1:0] cur_mode;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtrap_csr #(.XLEN(XLEN)) dut (.*);

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    exc_req = 0; irq_req = 0; mret = 0; csr_we = 0; csr_sel = 0;
  endtask

  task automatic step();
    @(posedge clk); #2; idle();
  endtask

  task automatic rd(input logic [1:0] s, output logic [XLEN-1:0] v);
    csr_sel = s; #1; v = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [XLEN-1:0] v);
    csr_we = 1; csr_sel = s; csr_wdata = v; step();
  endtask

  function automatic logic [XLEN-1:0] st(logic en, logic pen, logic [1:0] pm);
    logic [XLEN-1:0] r = '0;
    r[3] = en; r[7] = pen; r[12:11] = pm;
    return r;
  endfunction

  task automatic t_reset();
    logic [XLEN-1:0] v;
    chk("R1 mode", cur_mode, 2'b11);
    chk("R1 irq_en", irq_en, 0);
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 epc", v, 0);
    rd(2, v); chk("R1 vector", v, 0);
  endtask

  task automatic t_csr();
    logic [XLEN-1:0] v;
    wr(2, 32'h0000_1003); rd(2, v); chk("R7 vector low bits", v, 32'h1000);
    wr(1, 32'h2222_2227); rd(1, v); chk("R7 epc low bits", v, 32'h2222_2224);
    wr(0, st(0, 1, 2'b01) | 32'hFFFF_0000); rd(0, v); chk("R8 mpp 01->00, R6 layout", v, st(0, 1, 2'b00));
    wr(0, st(0, 0, 2'b11)); rd(0, v); chk("R8 mpp 11 kept", v, st(0, 0, 2'b11));
    wr(3, 32'hFFFF_FFFF); rd(3, v); chk("R6 sel 3 reads 0", v, 0);
    rd(2, v); chk("R6 sel 3 write ignored", v, 32'h1000);
  endtask

  task automatic t_mask();
    logic [XLEN-1:0] v;
    irq_req = 1; trap_pc = 32'h0000_0500; #1;
    chk("R2 masked no redirect", redirect_valid, 0);
    step();
    rd(1, v); chk("R2 masked epc unchanged", v, 32'h2222_2224);
    rd(0, v); chk("R2 masked status unchanged", v, st(0, 0, 2'b11));
  endtask

  task automatic t_irq();
    logic [XLEN-1:0] v;
    wr(0, st(1, 0, 2'b00));
    chk("R2 irq_en set", irq_en, 1);
    irq_req = 1; trap_pc = 32'h0000_0402; #1;
    chk("R2 redirect valid", redirect_valid, 1);
    chk("R2 redirect to vector", redirect_pc, 32'h1000);
    step();
    rd(0, v); chk("R3 status after trap", v, st(0, 1, 2'b11));
    rd(1, v); chk("R3 epc saved aligned", v, 32'h400);
    chk("R3 mode machine", cur_mode, 2'b11);
  endtask

  task automatic t_mret();
    logic [XLEN-1:0] v;
    mret = 1; #1;
    chk("R4 redirect valid", redirect_valid, 1);
    chk("R4 redirect to epc", redirect_pc, 32'h400);
    step();
    chk("R4 mode from mpp", cur_mode, 2'b11);
    chk("R4 enable from mpie", irq_en, 1);
    rd(0, v); chk("R4 mpie=1 mpp=U", v, st(1, 1, 2'b00));
    wr(0, st(1, 0, 2'b00));
    mret = 1; step();
    chk("R4 enter user mode", cur_mode, 2'b00);
    chk("R4 enable restored 0", irq_en, 0);
    exc_req = 1; trap_pc = 32'h0000_0800; #1;
    chk("R2 exception taken while masked", redirect_valid, 1);
    step();
    rd(0, v); chk("R3 user mode saved", v, st(0, 0, 2'b00));
    chk("R3 mode machine from user", cur_mode, 2'b11);
    mret = 1; step();
    chk("R4 return to user", cur_mode, 2'b00);
    exc_req = 1; trap_pc = 32'h0000_0900; step();
  endtask

  task automatic t_both();
    logic [XLEN-1:0] v;
    wr(0, st(1, 0, 2'b00));
    irq_req = 1; mret = 1; trap_pc = 32'h0000_0600; #1;
    chk("R5 redirect to vector", redirect_pc, 32'h1000);
    step();
    chk("R5 mode machine", cur_mode, 2'b11);
    rd(1, v); chk("R5 epc from trap", v, 32'h600);
    rd(0, v); chk("R5 status trap entry", v, st(0, 1, 2'b11));
  endtask

  task automatic t_wdrop();
    logic [XLEN-1:0] v;
    exc_req = 1; trap_pc = 32'h0000_0700;
    csr_we = 1; csr_sel = 2; csr_wdata = 32'h0000_9000; step();
    rd(2, v); chk("R9 vector write dropped on trap", v, 32'h1000);
    mret = 1; csr_we = 1; csr_sel = 1; csr_wdata = 32'h0000_A000; step();
    rd(1, v); chk("R9 epc write dropped on return", v, 32'h700);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_csr();
    t_mask();
    t_irq();
    t_mret();
    t_both();
    t_wdrop();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule